// File: doc/BRIEF.md
# Banked UART Host Register File

This block is the byte-wide register interface that a host processor sees when it drives a classic serial port. It decodes a 3-bit offset. A bank-select bit in the line-control register swaps the two 8-bit baud divisor bytes in place of the data and interrupt-enable locations. The block keeps a receive queue and a transmit queue, each 16 bytes deep. The host can enable the queues, flush them and set a receive trigger level through a write-only queue-control register.

The serial shifters are not part of this block. Each received byte arrives on a one-cycle strobe, together with its break, framing and parity error flags. Transmit bytes leave through a valid/ready pair. The block also keeps the line-status and modem-status flags. Some of these flags clear when their register is read. The interrupt identification code follows a fixed priority order. The 16-bit divisor is driven straight onto an output for an external baud generator.

A read returns its data on `bus_rdata` one clock after `bus_rd` is sampled. When no read was made in the previous cycle, `bus_rdata` is 0. Register side effects take effect on the same clock edge that samples the read or write.

Top module: `uart_regbank`

## Requirements
- R1: After reset, line status (offset 5) reads 0x60. Every other readable register, `divisor` and `tx_valid` are 0, with the modem inputs low. Offset 2 reads 0x01, which means no interrupt is pending.
- R2: While line-control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. `divisor` presents {high, low}. In that state, data writes do not reach the transmit queue.
- R3: Interrupt enable keeps only bits 3:0 and modem control keeps only bits 4:0. The bits above read as 0. The scratch register at offset 7 keeps all 8 bits.
- R4: Line-status bit 4 (break), bit 3 (framing) and bit 2 (parity) are set from `rx_err[2]`, `rx_err[1]` and `rx_err[0]` when a byte arrives. Reading offset 5 clears those three bits, but it does not clear overrun (bit 1).
- R5: Modem-status bits 7:4 show the level of `modem_in[3:0]` from the previous clock. Bits 3:0 are sticky flags that record a change on the matching line. Reading offset 6 clears the flags.
- R6: When queue-control bit 0 is 1, the receive queue holds 16 bytes in arrival order. A byte that arrives while the queue is full is dropped, and overrun (line-status bit 1) is set.
- R7: With the queues disabled, a new byte replaces the byte being held. If the held byte was still unread, overrun is set.
- R8: A data read that takes the last receive byte clears data-ready (bit 0) and overrun. A read from an empty receive queue returns 0 and changes no flag.
- R9: A data write clears holding-empty (bit 5) and transmitter-empty (bit 6). The oldest queued byte is shown on `tx_data` while `tx_valid` is high, and it leaves when `tx_ready` is high. A write to a full queue is dropped. With the queues disabled, a write replaces the pending byte. When the queue drains, both flags are set again.
- R10: A queue-control write with bit 1 flushes the receive queue, and one with bit 2 flushes the transmit queue. Clearing bit 0 while the queues are enabled flushes both.
- R11: Offset 2 reads 0x01 whenever modem-control bit 3 is 0. Otherwise the codes are taken in this priority order:
  - 0x06 for a line error (enable bit 2).
  - 0x04 when the receive count is at or above the trigger (enable bit 0). Queue-control bits 7:6 select a trigger of 1, 4, 8 or 14 bytes.
  - 0x0C when receive data is held below the trigger (enable bit 0).
  - 0x02 for holding-empty (enable bit 1).
  - 0x00 for a modem change (enable bit 3).
  - 0x01 when nothing is pending.
  
  While the queues are enabled, 0xC0 is ORed into the code.
- R12: Writes to offsets 5 and 6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, one cycle after the strobe |
| rx_strobe | input | 1 | Received byte present |
| rx_byte | input | 8 | Received byte |
| rx_err | input | 3 | {break, framing, parity} flags of the received byte |
| modem_in | input | 4 | Modem input lines |
| tx_data | output | 8 | Oldest pending transmit byte |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Shifter accepts the byte |
| divisor | output | 16 | Baud divisor {high, low} |

## Verification
An incorrect queue pointer or count shows up at the ports immediately. It gives a wrong byte, or the wrong order, on the next data read or on `tx_data`. It also makes data-ready, overrun or the empty flags wrong on the very next line-status read. A stale error or change flag becomes visible on the second of two back-to-back status reads, because it fails to clear. It also appears in the interrupt code, where the priority order exposes which condition the block believes is pending. A bank-select fault appears within one read of offset 0 or 1, or on the `divisor` output.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_IEN   = 3'd1;
  localparam logic [2:0] OFS_IDENT = 3'd2;
  localparam logic [2:0] OFS_LCTL  = 3'd3;
  localparam logic [2:0] OFS_MCTL  = 3'd4;
  localparam logic [2:0] OFS_LSTAT = 3'd5;
  localparam logic [2:0] OFS_MSTAT = 3'd6;
  localparam logic [2:0] OFS_SCR   = 3'd7;

  localparam int BANK_BIT  = 7;
  localparam int GATE_BIT  = 3;
  localparam int QEN_BIT   = 0;
  localparam int RXFL_BIT  = 1;
  localparam int TXFL_BIT  = 2;

  localparam logic [7:0] ID_NONE  = 8'h01;
  localparam logic [7:0] ID_LINE  = 8'h06;
  localparam logic [7:0] ID_RXTRG = 8'h04;
  localparam logic [7:0] ID_RXTMO = 8'h0C;
  localparam logic [7:0] ID_TXEMP = 8'h02;
  localparam logic [7:0] ID_MODEM = 8'h00;
  localparam logic [7:0] ID_QON   = 8'hC0;
endpackage

// File: rtl/uart_rb_fifo.sv
module uart_rb_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  assign full    = (count == CAP);
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it can map onto memory resources
  always_ff @(posedge clk) begin
    if (clr) begin
      if (push) mem[0] <= din;
    end else if (push_ok) begin
      mem[wr_ptr] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      // flush; a simultaneous push becomes the single entry
      rd_ptr <= '0;
      wr_ptr <= push ? step('0) : '0;
      count  <= push ? CW'(1) : '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/uart_rb_intid.sv
module uart_rb_intid #(
  parameter int CW = 5
) (
  input  logic          gate,
  input  logic          q_on,
  input  logic [3:0]    enables,
  input  logic          line_err,
  input  logic          rx_has,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] trig,
  input  logic          tx_empty,
  input  logic          modem_chg,
  output logic [7:0]    code
);
  import uart_regbank_pkg::*;
  logic [7:0] base;

  always_comb begin
    if (enables[2] && line_err)                       base = ID_LINE;
    else if (enables[0] && rx_has && rx_count >= trig) base = ID_RXTRG;
    else if (enables[0] && rx_has)                     base = ID_RXTMO;
    else if (enables[1] && tx_empty)                   base = ID_TXEMP;
    else if (enables[3] && modem_chg)                  base = ID_MODEM;
    else                                               base = ID_NONE;
    if (!gate)      code = ID_NONE;
    else if (q_on)  code = base | ID_QON;
    else            code = base;
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter int QDEPTH = 16,
  localparam int CW = $clog2(QDEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_rd,
  output logic [7:0]  bus_rdata,
  input  logic        rx_strobe,
  input  logic [7:0]  rx_byte,
  input  logic [2:0]  rx_err,
  input  logic [3:0]  modem_in,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [15:0] divisor
);
  import uart_regbank_pkg::*;

  logic [3:0] ien_q;
  logic [7:0] lctl_q;
  logic [4:0] mctl_q;
  logic [7:0] scr_q, dlo_q, dhi_q, rdata_q;
  logic       qon_q;
  logic [1:0] trig_sel_q;
  logic       ovr_q, brk_q, fer_q, per_q;
  logic [3:0] lines_q, chg_q;

  logic       bank;
  assign bank = lctl_q[BANK_BIT];

  // decoded strobes
  logic wr_data, wr_qctl, rd_data, rd_lstat, rd_mstat;
  assign wr_data  = bus_wr && bus_addr == OFS_DATA && !bank;
  assign wr_qctl  = bus_wr && bus_addr == OFS_IDENT;
  assign rd_data  = bus_rd && bus_addr == OFS_DATA && !bank;
  assign rd_lstat = bus_rd && bus_addr == OFS_LSTAT;
  assign rd_mstat = bus_rd && bus_addr == OFS_MSTAT;

  logic qoff_cmd;
  assign qoff_cmd = wr_qctl && qon_q && !bus_wdata[QEN_BIT];

  // receive and transmit queues
  logic          rx_clr, tx_clr, tx_pop;
  logic [7:0]    rx_head;
  logic [CW-1:0] rx_count, tx_count;
  logic          rx_full, rx_empty, tx_full, tx_empty;

  assign rx_clr = (wr_qctl && bus_wdata[RXFL_BIT]) || qoff_cmd || (rx_strobe && !qon_q);
  assign tx_clr = (wr_qctl && bus_wdata[TXFL_BIT]) || qoff_cmd || (wr_data && !qon_q);
  assign tx_pop = tx_valid && tx_ready;

  uart_rb_fifo #(.WIDTH(8), .DEPTH(QDEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_clr), .push(rx_strobe), .din(rx_byte),
    .pop(rd_data), .dout(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  uart_rb_fifo #(.WIDTH(8), .DEPTH(QDEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(tx_clr), .push(wr_data), .din(bus_wdata),
    .pop(tx_pop), .dout(tx_data), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  assign tx_valid = !tx_empty;

  // receive trigger level
  logic [CW-1:0] trig;
  always_comb begin
    case (trig_sel_q)
      2'd0:    trig = CW'(1);
      2'd1:    trig = CW'(4);
      2'd2:    trig = CW'(8);
      default: trig = CW'(14);
    endcase
  end

  // status words
  logic [7:0] lstat, mstat, ident;
  assign lstat = {1'b0, tx_empty, tx_empty, brk_q, fer_q, per_q, ovr_q, !rx_empty};
  assign mstat = {lines_q, chg_q};

  uart_rb_intid #(.CW(CW)) u_id (
    .gate(mctl_q[GATE_BIT]), .q_on(qon_q), .enables(ien_q),
    .line_err(brk_q || fer_q || per_q || ovr_q), .rx_has(!rx_empty),
    .rx_count(rx_count), .trig(trig), .tx_empty(tx_empty),
    .modem_chg(chg_q != 4'd0), .code(ident)
  );

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q      <= '0;
      lctl_q     <= '0;
      mctl_q     <= '0;
      scr_q      <= '0;
      dlo_q      <= '0;
      dhi_q      <= '0;
      qon_q      <= 1'b0;
      trig_sel_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_DATA:  if (bank) dlo_q <= bus_wdata;
        OFS_IEN:   if (bank) dhi_q <= bus_wdata; else ien_q <= bus_wdata[3:0];
        OFS_IDENT: begin
          qon_q      <= bus_wdata[QEN_BIT];
          trig_sel_q <= bus_wdata[7:6];
        end
        OFS_LCTL:  lctl_q <= bus_wdata;
        OFS_MCTL:  mctl_q <= bus_wdata[4:0];
        OFS_SCR:   scr_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  // line-status flags: set on arrival wins over clear
  logic ovr_set;
  assign ovr_set = rx_strobe && (qon_q ? rx_full : !rx_empty);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= 1'b0;
      brk_q <= 1'b0;
      fer_q <= 1'b0;
      per_q <= 1'b0;
    end else begin
      if (ovr_set)                                  ovr_q <= 1'b1;
      else if (rd_data && rx_count == CW'(1) && !rx_clr) ovr_q <= 1'b0;
      brk_q <= (rx_strobe && rx_err[2]) || (brk_q && !rd_lstat);
      fer_q <= (rx_strobe && rx_err[1]) || (fer_q && !rd_lstat);
      per_q <= (rx_strobe && rx_err[0]) || (per_q && !rd_lstat);
    end
  end

  // modem-status tracking
  logic [3:0] diff;
  assign diff = modem_in ^ lines_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lines_q <= '0;
      chg_q   <= '0;
    end else begin
      lines_q <= modem_in;
      chg_q   <= rd_mstat ? diff : (chg_q | diff);
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_DATA:  rdata_q <= bank ? dlo_q : (rx_empty ? 8'h00 : rx_head);
        OFS_IEN:   rdata_q <= bank ? dhi_q : {4'h0, ien_q};
        OFS_IDENT: rdata_q <= ident;
        OFS_LCTL:  rdata_q <= lctl_q;
        OFS_MCTL:  rdata_q <= {3'b000, mctl_q};
        OFS_LSTAT: rdata_q <= lstat;
        OFS_MSTAT: rdata_q <= mstat;
        default:   rdata_q <= scr_q;
      endcase
    end else begin
      rdata_q <= '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign divisor   = {dhi_q, dlo_q};
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_rdata,
  input logic [7:0]  tx_data,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [15:0] divisor,
  input logic        bank
);
  // R2: the divisor changes only as a result of a bus write
  p_divisor_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(divisor));

  // R3: enable register upper bits read as zero
  p_ien_upper_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 3'd1 && !bank) |=> bus_rdata[7:4] == 4'h0);

  // R9: a stalled transmit byte stays put while no bus write intervenes
  p_tx_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !bus_wr) |=> (tx_valid && $stable(tx_data)));

  // R1: read data is zero in a cycle that follows no read
  p_rdata_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == 8'h00);

  // R5: modem-status upper nibble never has bits 7:4 unknown-driven by a read of offset 6
  p_mstat_known_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 3'd6) |=> !$isunknown(bus_rdata));
endmodule

bind uart_regbank uart_regbank_chk u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .divisor(divisor), .bank(lctl_q[7])
);

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        rx_strobe = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic [2:0]  rx_err = '0;
  logic [3:0]  modem_in = '0;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [15:0] divisor;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_regbank u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
    .rx_err(rx_err), .modem_in(modem_in), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .divisor(divisor)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // scoreboard of expected read data
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", 16'd1, 16'd0);
      end else begin
        check(tag_q.pop_front(), {8'h00, bus_rdata}, {8'h00, exp_q.pop_front()});
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx(input logic [7:0] b, input logic [2:0] err);
    rx_byte = b; rx_err = err; rx_strobe = 1'b1;
    @(negedge clk);
    rx_strobe = 1'b0; rx_err = '0;
  endtask

  task automatic tx_take(input logic [7:0] e, input string tag);
    check(tag, {7'd0, tx_valid, tx_data}, {8'h01, e});
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(5, 8'h60, "R1 lstat");
    rd(3, 8'h00, "R1 lctl");
    rd(1, 8'h00, "R1 ien");
    rd(4, 8'h00, "R1 mctl");
    rd(7, 8'h00, "R1 scr");
    rd(6, 8'h00, "R1 mstat");
    rd(2, 8'h01, "R1 ident");
    check("R1 divisor", divisor, 16'h0000);
    check("R1 tx_valid", {15'd0, tx_valid}, 16'd0);
    // R3 masked storage
    wr(1, 8'hFF); rd(1, 8'h0F, "R3 ien mask");
    wr(4, 8'hFF); rd(4, 8'h1F, "R3 mctl mask");
    wr(7, 8'hA5); rd(7, 8'hA5, "R3 scratch");
    wr(1, 8'h00); wr(4, 8'h00);
    // R2 divisor banking
    wr(3, 8'h80); wr(0, 8'h34); wr(1, 8'h12);
    check("R2 divisor out", divisor, 16'h1234);
    rd(0, 8'h34, "R2 low byte");
    rd(1, 8'h12, "R2 high byte");
    check("R2 no tx push", {15'd0, tx_valid}, 16'd0);
    wr(3, 8'h03);
    rd(3, 8'h03, "R2 lctl");
    rd(1, 8'h00, "R2 ien unbanked");
    check("R2 divisor kept", divisor, 16'h1234);
    // R12 read-only offsets
    wr(5, 8'h00); rd(5, 8'h60, "R12 lstat write ignored");
    wr(6, 8'hFF); rd(6, 8'h00, "R12 mstat write ignored");
    // R7 non-queue receive
    rx(8'h11, 3'b000); rd(5, 8'h61, "R7 ready");
    rx(8'h22, 3'b000); rd(5, 8'h63, "R7 overrun");
    rd(0, 8'h22, "R7 replaced byte");
    rd(5, 8'h60, "R8 ovr cleared");
    rd(0, 8'h00, "R8 empty read");
    rd(5, 8'h60, "R8 empty read no flags");
    // R4 error bits
    rx(8'h55, 3'b111);
    rd(5, 8'h7D, "R4 errors set");
    rd(5, 8'h61, "R4 errors cleared");
    rd(0, 8'h55, "R4 data");
    rd(5, 8'h60, "R4 drained");
    // R6 queued receive
    wr(2, 8'h01);
    for (int i = 0; i < 16; i++) rx(8'h80 + 8'(i), 3'b000);
    rd(5, 8'h61, "R6 full no ovr");
    rx(8'h99, 3'b000);
    rd(5, 8'h63, "R6 overrun");
    for (int i = 0; i < 16; i++) rd(0, 8'h80 + 8'(i), "R6 order");
    rd(5, 8'h60, "R8 drain clears");
    rd(2, 8'h01, "R11 gate off");
    // R11 identification priority
    wr(4, 8'h08); wr(1, 8'h0F);
    rd(2, 8'hC2, "R11 tx empty");
    wr(2, 8'h41);
    for (int i = 0; i < 3; i++) rx(8'h40 + 8'(i), 3'b000);
    rd(2, 8'hCC, "R11 below trigger");
    rx(8'h43, 3'b000);
    rd(2, 8'hC4, "R11 trigger 4");
    rx(8'h44, 3'b001);
    rd(2, 8'hC6, "R11 line error");
    rd(5, 8'h65, "R4 parity");
    rd(2, 8'hC4, "R11 after clear");
    wr(2, 8'h43);
    rd(5, 8'h60, "R10 rx flush");
    rd(2, 8'hC2, "R11 tx after flush");
    wr(1, 8'h0D);
    modem_in = 4'b0001;
    @(negedge clk);
    rd(2, 8'hC0, "R11 modem change");
    rd(6, 8'h11, "R5 change set");
    rd(6, 8'h10, "R5 change cleared");
    rd(2, 8'hC1, "R11 none pending");
    modem_in = 4'b0000;
    @(negedge clk);
    rd(6, 8'h01, "R5 fall change");
    // R9 transmit
    wr(1, 8'h00); wr(4, 8'h00);
    wr(0, 8'hA1);
    rd(5, 8'h00, "R9 empties cleared");
    wr(0, 8'hA2); wr(0, 8'hA3);
    tx_take(8'hA1, "R9 tx first");
    tx_take(8'hA2, "R9 tx second");
    tx_take(8'hA3, "R9 tx third");
    check("R9 drained", {15'd0, tx_valid}, 16'd0);
    rd(5, 8'h60, "R9 empties set");
    for (int i = 0; i < 17; i++) wr(0, 8'hB0 + 8'(i));
    for (int i = 0; i < 16; i++) tx_take(8'hB0 + 8'(i), "R9 full queue");
    check("R9 overflow dropped", {15'd0, tx_valid}, 16'd0);
    // R10 flushes
    wr(0, 8'hC1); wr(0, 8'hC2);
    wr(2, 8'h05);
    check("R10 tx flush", {15'd0, tx_valid}, 16'd0);
    rd(5, 8'h60, "R10 tx flags");
    rx(8'h77, 3'b000); wr(0, 8'hD1);
    wr(2, 8'h00);
    check("R10 disable flush tx", {15'd0, tx_valid}, 16'd0);
    rd(5, 8'h60, "R10 disable flush rx");
    // R9 non-queue replace
    wr(0, 8'hE1); wr(0, 8'hE2);
    tx_take(8'hE2, "R9 replace");
    check("R9 single drained", {15'd0, tx_valid}, 16'd0);
    repeat (3) @(negedge clk);
    check("scoreboard empty", 16'(exp_q.size()), 16'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule